// File: doc/BRIEF.md
# Video Address and Scroll Register File

This block is the processor-facing register file of a tile-based video engine. The processor writes bytes into eight register slots. The slot number comes from the low three bits of the processor address, so the eight slots repeat across the whole address window. The block holds four pieces of state: a 15-bit staging address, a 15-bit live video-memory address, a 3-bit fine horizontal scroll value and a single toggle. The scroll port and the address port share that toggle, and it tells each of them whether the next byte is the first or the second of a pair.

A control slot and a display-option slot drive the static outputs. These are the address step, the two pattern-table bases, the sprite height, the vertical-blank interrupt enable, the colour mask, the emphasis field, the left-column clip enables and the layer enables. A write to the data slot goes to one of three places, chosen by the live address. It raises a pattern-memory write strobe, or a nametable write strobe, or it writes a 32-entry palette held inside the block. After each data write the live address moves on by the chosen step. A separate one-cycle pulse, raised when the status register is read, returns the toggle to its first-write state.

Top module: `vram_regs`

## Requirements
- R1: The register slot is taken from wr_addr[2:0] alone. Any address with the same low three bits reaches the same slot. Slots 2, 3 and 4 have no effect on any output.
- R2: A write to slot 0 stores value bits 1:0 in staging bits 11:10 and leaves the other staging bits as they were. Bit 2 sets the step to 32 when 1 and to 1 when 0. Bit 3 sets the sprite base to 0x1000, else 0x0000. Bit 4 sets the background base to 0x1000, else 0x0000. Bit 5 sets the sprite height to 16, else 8. Bit 7 drives nmi_en.
- R3: A write to slot 1 drives the following outputs. Bit 0 gives a colour mask of 0x30 when 1 and 0x3F when 0. Bits 7:5 give emph. Bit 1 clear gives bg_clip=1 and bit 2 clear gives spr_clip=1. Bit 3 drives bg_en and bit 4 drives spr_en.
- R4: When the toggle is 0, a write to slot 5 puts value bits 7:3 in staging bits 4:0 and value bits 2:0 in fine_x. When the toggle is 1, it puts value bits 2:0 in staging bits 14:12 and value bits 7:3 in staging bits 9:5. No other write changes fine_x.
- R5: When the toggle is 0, a write to slot 6 puts value bits 5:0 in staging bits 13:8 and clears staging bit 14. When the toggle is 1, it puts the value in staging bits 7:0 and copies the whole result into the live address. Only a slot 6 write with the toggle at 1, or a slot 7 write, changes the live address.
- R6: Each write to slot 5 or slot 6 flips the toggle, and no other slot changes it. A status_rd pulse forces the toggle to 0 and wins over a flip in the same cycle. The write in that cycle still acts on the toggle value it had before the edge.
- R7: In the cycle of a slot 7 write the block looks at the access address, which is the live address taken to 14 bits. If it is below 0x2000, pat_we is high. If it is from 0x2000 to 0x3EFF, nt_we is high. If it is 0x3F00 or above, the palette is written and neither strobe is high. vram_addr shows the access address and vram_data shows the byte.
- R8: The palette index is access address AND 0x0C when address bits 1:0 are zero, and access address AND 0x1F otherwise. pal_rd_data shows entry pal_rd_idx without delay.
- R9: After every slot 7 write the live address grows by the step. The sum wraps modulo 2^15.
- R10: After reset every held register and palette entry is zero. That gives step 1, both bases 0, height 8, nmi_en 0, colour mask 0x3F, both clip outputs 1, both enables 0, staging, live address, fine_x and toggle all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | CPU_AW | Processor address; bits 2:0 pick the slot |
| wr_data | input | 8 | Write byte |
| status_rd | input | 1 | Status-read pulse; resets the toggle |
| pal_rd_idx | input | 5 | Palette entry to show |
| pal_rd_data | output | 8 | Palette entry contents |
| inc_step | output | 6 | Live address step, 1 or 32 |
| spr_pt_base | output | 13 | Sprite pattern base |
| bg_pt_base | output | 13 | Background pattern base |
| spr_height | output | 5 | Sprite height, 8 or 16 |
| nmi_en | output | 1 | Vertical-blank interrupt enable |
| color_mask | output | 6 | Colour mask, 0x30 or 0x3F |
| emph | output | 3 | Colour emphasis field |
| bg_clip | output | 1 | Background left-column clip enabled |
| spr_clip | output | 1 | Sprite left-column clip enabled |
| bg_en | output | 1 | Background layer enable |
| spr_en | output | 1 | Sprite layer enable |
| tmp_addr | output | 15 | Staging address |
| cur_addr | output | 15 | Live video-memory address |
| fine_x | output | 3 | Fine horizontal scroll |
| second_wr | output | 1 | Toggle: 1 means the next scroll or address byte is the second |
| pat_we | output | 1 | Pattern-memory write strobe |
| nt_we | output | 1 | Nametable write strobe |
| vram_addr | output | 14 | Access address for the strobes |
| vram_data | output | 8 | Write byte for the strobes |

## Verification
The bench builds a live address of 0x7FFF by using a second scroll write to set staging bit 14, then finishing with a second address byte. It then writes the data port. A design that masks the live address before the increment, or that fails to wrap at 15 bits, shows the wrong address afterwards. A design that forgets the 14-bit access mask raises no palette write at entry 0x1F.

The bench aims writes at both sides of the 0x2000 and 0x3F00 boundaries, and at backdrop palette addresses such as 0x3F10 and 0x3F1C. An off-by-one compare sends a byte to the wrong memory. A missing fold writes entry 0x10 where entry 0x00 should change.

The toggle is tested three ways. A control write must leave it alone. Interleaved scroll and address writes must share it. A status pulse in the same cycle as a second address byte must still let that byte load the live address. A design that keeps two toggles, or that gives the pulse priority over the write data, fails these checks.

// File: rtl/vram_regs.sv
module vram_regs #(
  parameter int CPU_AW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CPU_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              status_rd,
  input  logic [4:0]        pal_rd_idx,
  output logic [7:0]        pal_rd_data,
  output logic [5:0]        inc_step,
  output logic [12:0]       spr_pt_base,
  output logic [12:0]       bg_pt_base,
  output logic [4:0]        spr_height,
  output logic              nmi_en,
  output logic [5:0]        color_mask,
  output logic [2:0]        emph,
  output logic              bg_clip,
  output logic              spr_clip,
  output logic              bg_en,
  output logic              spr_en,
  output logic [14:0]       tmp_addr,
  output logic [14:0]       cur_addr,
  output logic [2:0]        fine_x,
  output logic              second_wr,
  output logic              pat_we,
  output logic              nt_we,
  output logic [13:0]       vram_addr,
  output logic [7:0]        vram_data
);

  localparam int PAL_N = 32;

  logic [7:0]  ctrl_q, mask_q;
  logic [14:0] tmp_q, cur_q;
  logic [2:0]  fine_q;
  logic        tgl_q;
  logic [7:0]  pal [PAL_N];

  logic [2:0]  slot;
  logic        wr_ctrl, wr_mask, wr_scrl, wr_adr, wr_dat;
  logic [13:0] acc;
  logic        pal_we;
  logic [4:0]  pal_idx;

  assign slot    = wr_addr[2:0];
  assign wr_ctrl = wr_en && slot == 3'd0;
  assign wr_mask = wr_en && slot == 3'd1;
  assign wr_scrl = wr_en && slot == 3'd5;
  assign wr_adr  = wr_en && slot == 3'd6;
  assign wr_dat  = wr_en && slot == 3'd7;

  assign acc     = cur_q[13:0];
  assign pat_we  = wr_dat && acc < 14'h2000;
  assign nt_we   = wr_dat && acc >= 14'h2000 && acc < 14'h3F00;
  assign pal_we  = wr_dat && acc >= 14'h3F00;
  assign pal_idx = (acc[1:0] == 2'b00) ? (acc[4:0] & 5'h0C) : acc[4:0];

  assign vram_addr = acc;
  assign vram_data = wr_data;

  assign inc_step    = ctrl_q[2] ? 6'd32 : 6'd1;
  assign spr_pt_base = ctrl_q[3] ? 13'h1000 : 13'h0000;
  assign bg_pt_base  = ctrl_q[4] ? 13'h1000 : 13'h0000;
  assign spr_height  = ctrl_q[5] ? 5'd16 : 5'd8;
  assign nmi_en      = ctrl_q[7];

  assign color_mask = mask_q[0] ? 6'h30 : 6'h3F;
  assign emph       = mask_q[7:5];
  assign bg_clip    = !mask_q[1];
  assign spr_clip   = !mask_q[2];
  assign bg_en      = mask_q[3];
  assign spr_en     = mask_q[4];

  assign tmp_addr    = tmp_q;
  assign cur_addr    = cur_q;
  assign fine_x      = fine_q;
  assign second_wr   = tgl_q;
  assign pal_rd_data = pal[pal_rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      tmp_q  <= '0;
      cur_q  <= '0;
      fine_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q       <= wr_data;
        tmp_q[11:10] <= wr_data[1:0];
      end
      if (wr_mask) mask_q <= wr_data;
      if (wr_scrl) begin
        if (!tgl_q) begin
          tmp_q[4:0] <= wr_data[7:3];
          fine_q     <= wr_data[2:0];
        end else begin
          tmp_q[14:12] <= wr_data[2:0];
          tmp_q[9:5]   <= wr_data[7:3];
        end
      end
      if (wr_adr) begin
        if (!tgl_q) begin
          tmp_q[13:8] <= wr_data[5:0];
          tmp_q[14]   <= 1'b0;
        end else begin
          tmp_q[7:0] <= wr_data;
          cur_q      <= {tmp_q[14:8], wr_data};
        end
      end
      if (wr_dat) cur_q <= cur_q + {9'd0, inc_step};
      if (status_rd) tgl_q <= 1'b0;
      else if (wr_scrl || wr_adr) tgl_q <= !tgl_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAL_N; i++) pal[i] <= '0;
    end else if (pal_we) begin
      pal[pal_idx] <= wr_data;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pat_we, nt_we, pal_we})); // R7
  AST_STRB_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_we || nt_we) |-> (wr_en && wr_addr[2:0] == 3'd7)); // R7
  AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr[2:0] == 3'd5 || wr_addr[2:0] == 3'd6) && !status_rd)
      |=> (second_wr != $past(second_wr))); // R6
  AST_STATUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> !second_wr); // R6
  AST_CUR_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[2:0] == 3'd7)
      |=> (cur_addr == 15'($past(cur_addr) + 15'($past(inc_step))))); // R9
  AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr[2:0] == 3'd7 || (wr_addr[2:0] == 3'd6 && second_wr)))
      |=> $stable(cur_addr)); // R5
  AST_TMP14_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[2:0] == 3'd6 && !second_wr) |=> !tmp_addr[14]); // R5
  AST_FINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr[2:0] == 3'd5 && !second_wr) |=> $stable(fine_x)); // R4

endmodule

// File: tb/sim_vram_regs.sv
module sim_vram_regs;
  logic clk = 0, rst_n = 0, wr_en = 0, status_rd = 0;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [4:0]  pal_rd_idx = '0;
  logic [7:0]  pal_rd_data;
  logic [5:0]  inc_step;
  logic [12:0] spr_pt_base, bg_pt_base;
  logic [4:0]  spr_height;
  logic        nmi_en, bg_clip, spr_clip, bg_en, spr_en, second_wr, pat_we, nt_we;
  logic [5:0]  color_mask;
  logic [2:0]  emph, fine_x;
  logic [14:0] tmp_addr, cur_addr;
  logic [13:0] vram_addr;
  logic [7:0]  vram_data;
  int checks = 0, errors = 0;

  always #10 clk = !clk;

  vram_regs u0 (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic set_cur(logic [13:0] v);
    status_rd = 1; @(negedge clk); status_rd = 0;
    wr(13'd6, {2'b0, v[13:8]});
    wr(13'd6, v[7:0]);
  endtask

  task automatic data_wr(logic [7:0] d, bit ep, bit en, logic [13:0] ea);
    @(negedge clk); wr_en = 1; wr_addr = 13'd7; wr_data = d;
    #5;
    chk("R7 pat_we", pat_we, ep);
    chk("R7 nt_we", nt_we, en);
    if (ep || en) begin
      chk("R7 vram_addr", vram_addr, ea);
      chk("R7 vram_data", vram_data, d);
    end
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pal_chk(string tag, int idx, int exp);
    pal_rd_idx = 5'(idx); #1;
    chk(tag, pal_rd_data, exp);
  endtask

  task automatic t_reset;
    chk("R10 step", inc_step, 1);
    chk("R10 spr base", spr_pt_base, 0);
    chk("R10 bg base", bg_pt_base, 0);
    chk("R10 height", spr_height, 8);
    chk("R10 nmi", nmi_en, 0);
    chk("R10 cmask", color_mask, 'h3F);
    chk("R10 clip", {bg_clip, spr_clip}, 3);
    chk("R10 en", {bg_en, spr_en}, 0);
    chk("R10 tmp", tmp_addr, 0);
    chk("R10 cur", cur_addr, 0);
    chk("R10 fine", fine_x, 0);
    chk("R10 tgl", second_wr, 0);
    pal_chk("R10 pal", 5, 0);
  endtask

  task automatic t_ctrl;
    wr(13'd0, 8'hBF);
    chk("R2 tmp11:10", tmp_addr, 'h0C00);
    chk("R2 step32", inc_step, 32);
    chk("R2 spr base", spr_pt_base, 'h1000);
    chk("R2 bg base", bg_pt_base, 'h1000);
    chk("R2 h16", spr_height, 16);
    chk("R2 nmi", nmi_en, 1);
    wr(13'd0, 8'h00);
    chk("R2 clear", {inc_step, spr_height, nmi_en}, {6'd1, 5'd8, 1'b0});
    wr(13'd5, 8'hF8);
    wr(13'd0, 8'h01);
    chk("R2 keep other tmp", tmp_addr, 'h041F);
    chk("R6 ctrl no flip", second_wr, 1);
    status_rd = 1; @(negedge clk); status_rd = 0;
    chk("R6 status clears", second_wr, 0);
  endtask

  task automatic t_mask;
    wr(13'd1, 8'hA1);
    chk("R3 cmask30", color_mask, 'h30);
    chk("R3 emph", emph, 5);
    chk("R3 clip on", {bg_clip, spr_clip}, 3);
    chk("R3 en off", {bg_en, spr_en}, 0);
    wr(13'd1, 8'h5E);
    chk("R3 cmask3F", color_mask, 'h3F);
    chk("R3 emph2", emph, 2);
    chk("R3 clip off", {bg_clip, spr_clip}, 0);
    chk("R3 en on", {bg_en, spr_en}, 3);
  endtask

  task automatic t_scroll_addr;
    set_cur(14'h0000);
    wr(13'd5, 8'h7D);
    chk("R4 first tmp", tmp_addr, 'h000F);
    chk("R4 fine", fine_x, 5);
    chk("R6 flip1", second_wr, 1);
    wr(13'd5, 8'h5E);
    chk("R4 second tmp", tmp_addr, 'h616F);
    chk("R4 fine kept", fine_x, 5);
    chk("R6 flip0", second_wr, 0);
    chk("R5 cur untouched", cur_addr, 0);
    wr(13'd6, 8'h7F);
    chk("R5 first addr", tmp_addr, 'h3F6F);
    chk("R5 cur still", cur_addr, 0);
    wr(13'd6, 8'h12);
    chk("R5 second addr", tmp_addr, 'h3F12);
    chk("R5 copy", cur_addr, 'h3F12);
    chk("R4 fine after addr", fine_x, 5);
  endtask

  task automatic t_mirror;
    wr(13'h1FFE, 8'h21);
    wr(13'h0A0E, 8'h08);
    chk("R1 mirrored addr", cur_addr, 'h2108);
    wr(13'h0002, 8'hFF);
    wr(13'h1FFB, 8'hFF);
    wr(13'h0104, 8'hFF);
    chk("R1 ignored tgl", second_wr, 0);
    chk("R1 ignored tmp", tmp_addr, 'h2108);
    chk("R1 ignored cur", cur_addr, 'h2108);
    chk("R1 ignored ctrl", {inc_step, nmi_en}, {6'd1, 1'b0});
  endtask

  task automatic t_data;
    wr(13'd0, 8'h00);
    set_cur(14'h0123);
    data_wr(8'hAB, 1, 0, 14'h0123);
    chk("R9 +1", cur_addr, 'h0124);
    set_cur(14'h1FFF);
    data_wr(8'h01, 1, 0, 14'h1FFF);
    set_cur(14'h2000);
    data_wr(8'h02, 0, 1, 14'h2000);
    wr(13'd0, 8'h04);
    set_cur(14'h23C0);
    data_wr(8'h03, 0, 1, 14'h23C0);
    chk("R9 +32", cur_addr, 'h23E0);
    wr(13'd0, 8'h00);
    set_cur(14'h3EFF);
    data_wr(8'h04, 0, 1, 14'h3EFF);
    chk("R7 edge to pal", cur_addr, 'h3F00);
    data_wr(8'h55, 0, 0, 14'h0);
    pal_chk("R8 3F00", 0, 'h55);
  endtask

  task automatic t_palette;
    set_cur(14'h3F10);
    data_wr(8'h11, 0, 0, 14'h0);
    pal_chk("R8 fold 10->00", 0, 'h11);
    pal_chk("R8 no 10", 'h10, 0);
    data_wr(8'h22, 0, 0, 14'h0);
    pal_chk("R8 11", 'h11, 'h22);
    set_cur(14'h3F1C);
    data_wr(8'h33, 0, 0, 14'h0);
    pal_chk("R8 fold 1C->0C", 'h0C, 'h33);
    pal_chk("R8 no 1C", 'h1C, 0);
    set_cur(14'h3F25);
    data_wr(8'h66, 0, 0, 14'h0);
    pal_chk("R8 mirror 25->05", 5, 'h66);
  endtask

  task automatic t_wrap;
    wr(13'd0, 8'h03);
    status_rd = 1; @(negedge clk); status_rd = 0;
    wr(13'd5, 8'hF8);
    wr(13'd5, 8'hFF);
    wr(13'd5, 8'hF8);
    wr(13'd6, 8'hFF);
    chk("R5 cur 7FFF", cur_addr, 'h7FFF);
    data_wr(8'h44, 0, 0, 14'h0);
    pal_chk("R7 14-bit mask pal", 'h1F, 'h44);
    chk("R9 wrap", cur_addr, 0);
    wr(13'd0, 8'h00);
  endtask

  task automatic t_status_prio;
    set_cur(14'h0000);
    wr(13'd6, 8'h15);
    chk("R6 pre", second_wr, 1);
    @(negedge clk); wr_en = 1; wr_addr = 13'd6; wr_data = 8'h9A; status_rd = 1;
    @(negedge clk); wr_en = 0; status_rd = 0;
    chk("R6 write used old tgl", cur_addr, 'h159A);
    chk("R6 status wins", second_wr, 0);
    @(negedge clk); wr_en = 1; wr_addr = 13'd5; wr_data = 8'h07; status_rd = 1;
    @(negedge clk); wr_en = 0; status_rd = 0;
    chk("R6 scroll first w/ status", fine_x, 7);
    chk("R6 tgl zero", second_wr, 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_mask();
    t_scroll_addr();
    t_mirror();
    t_data();
    t_palette();
    t_wrap();
    t_status_prio();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule